// File: doc/BRIEF.md
# Cascadable Serial Segment Data Loader

This block takes LCD segment data over a three-wire serial link (data, shift clock, load) and presents it as parallel segment bits. A shift chain of two banks of `SEGS` stages advances one stage on every rising edge of the shift clock. In static mode only bank A (`SEGS` bits) matters. In half-duty mode both banks (A and B) are filled in one pass of `2*SEGS` bits. A latch per bank passes the chain contents to the segment outputs while load is high and freezes them while load is low.

For cascading, the block drives the last relevant chain stage on a serial output that changes on the falling shift-clock edge. It also drives buffered copies of the shift clock, load, all-on test and blank inputs for the next device. The serial pins are sampled inputs in a faster system clock domain. They pass through a two-flop synchroniser, and their edges are detected synchronously. Each shift-clock phase must last at least two system clocks.

Top module: `seg_serial_loader`

## Requirements
- R1: After asynchronous active-low reset, `bank_a_o`, `bank_b_o` and `sdata_o` are all zero.
- R2: A rising shift-clock edge moves the chain one stage and captures `sdata_i` into stage 1 (bit 0). After `SEGS` edges, segment k sits at `bank_a_o[k-1]`, which means the bit for segment `SEGS` is shifted first. A value of 1 means the segment is on.
- R3: `sdata_o` changes only after a falling shift-clock edge. In static mode (`half_duty_i`=0) it then shows chain stage `SEGS` (bank A, last stage).
- R4: In half-duty mode (`half_duty_i`=1), `sdata_o` after a falling edge shows chain stage `2*SEGS` (bank B, last stage).
- R5: Bank A stage `SEGS` feeds bank B stage 1. After `2*SEGS` edges in half-duty mode, the first `SEGS` bits sent are in `bank_b_o` and the last `SEGS` bits are in `bank_a_o`, with the first bit sent at `bank_b_o[SEGS-1]`.
- R6: While the synchronised load is high, the bank outputs follow the chain, including shifts made during that time. A rising shift edge seen in the same sample as load high is already visible.
- R7: While load is low, the bank outputs hold the chain value from the last sample in which load was high. A rising shift edge seen in the same sample that load is seen low is not captured.
- R8: In static mode `bank_b_o` reads all zeros whatever bank B holds.
- R9: `sclk_o`, `load_o`, `test_o` and `blank_o` repeat `sclk_i`, `load_i`, `test_i` and `blank_i` one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| half_duty_i | input | 1 | 1: two-bank half-duty chain, 0: static (bank A only) |
| sdata_i | input | 1 | Serial segment data |
| sclk_i | input | 1 | Shift clock (sampled) |
| load_i | input | 1 | Latch enable, transparent when high |
| test_i | input | 1 | All-segments-on request, forwarded |
| blank_i | input | 1 | All-segments-off request, forwarded |
| sdata_o | output | 1 | Serial data to next device |
| sclk_o | output | 1 | Buffered shift clock |
| load_o | output | 1 | Buffered load |
| test_o | output | 1 | Buffered test |
| blank_o | output | 1 | Buffered blank |
| bank_a_o | output | SEGS | Latched bank A, bit k-1 is segment k |
| bank_b_o | output | SEGS | Latched bank B (zero in static mode) |

## Verification
A rising shift edge and a change of load can reach the latch in the same system clock. Which chain value the latch keeps then depends on the order of update inside that clock. The bench provokes this by toggling the shift clock and load on the same driving edge, in both directions. Dropping load together with the rise must leave the pre-shift contents on the banks. Raising load together with the rise must show the post-shift contents. A bit-accurate chain model in the bench supplies the expected bank values for both cases.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;
  typedef struct packed {
    logic sclk;
    logic sdata;
    logic load;
    logic test;
    logic blank;
  } ser_pins_t;
endpackage

// File: rtl/seg_in_sync.sv
module seg_in_sync
  import seg_loader_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  ser_pins_t raw_i,
  output ser_pins_t now_o,
  output logic      rise_o,
  output logic      fall_o
);
  ser_pins_t s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign now_o  = s1_q;
  assign rise_o = s1_q.sclk & ~s2_q.sclk;
  assign fall_o = ~s1_q.sclk & s2_q.sclk;

  assert_buffer_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> now_o == $past(raw_i));
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int unsigned SEGS = 160
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic                din_i,
  input  logic                fall_i,
  input  logic                half_i,
  output logic [2*SEGS-1:0]   chain_nxt_o,
  output logic                sdata_o
);
  localparam int unsigned CHAIN = 2 * SEGS;

  logic [CHAIN-1:0] chain_q;
  logic             sdata_q;

  // bank A stage SEGS (index SEGS-1) feeds bank B stage 1 (index SEGS)
  always_comb chain_nxt_o = shift_i ? {chain_q[CHAIN-2:0], din_i} : chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      sdata_q <= 1'b0;
    end else begin
      chain_q <= chain_nxt_o;
      if (fall_i) sdata_q <= half_i ? chain_q[CHAIN-1] : chain_q[SEGS-1];
    end
  end

  assign sdata_o = sdata_q;

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> chain_q[0] == $past(din_i));
  assert_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> chain_q[CHAIN-1:1] == $past(chain_q[CHAIN-2:0]));
  assert_out_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(sdata_o));
endmodule

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int unsigned W = 160
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         open_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (open_i) q_o <= d_i;
  end

  assert_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i |=> q_o == $past(d_i));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_i |=> $stable(q_o));
endmodule

// File: rtl/seg_serial_loader.sv
module seg_serial_loader
  import seg_loader_pkg::*;
#(
  parameter int unsigned SEGS = 160
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            half_duty_i,
  input  logic            sdata_i,
  input  logic            sclk_i,
  input  logic            load_i,
  input  logic            test_i,
  input  logic            blank_i,
  output logic            sdata_o,
  output logic            sclk_o,
  output logic            load_o,
  output logic            test_o,
  output logic            blank_o,
  output logic [SEGS-1:0] bank_a_o,
  output logic [SEGS-1:0] bank_b_o
);
  localparam int unsigned BANKS = 2;

  ser_pins_t             raw, now;
  logic                  rise, fall;
  logic [2*SEGS-1:0]     chain_nxt;
  logic [SEGS-1:0]       lat [BANKS];

  assign raw = '{sclk: sclk_i, sdata: sdata_i, load: load_i, test: test_i, blank: blank_i};

  seg_in_sync u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (raw),
    .now_o (now),
    .rise_o(rise),
    .fall_o(fall)
  );

  seg_shift_chain #(.SEGS(SEGS)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (rise),
    .din_i      (now.sdata),
    .fall_i     (fall),
    .half_i     (half_duty_i),
    .chain_nxt_o(chain_nxt),
    .sdata_o    (sdata_o)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    seg_hold_latch #(.W(SEGS)) u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .open_i(now.load),
      .d_i   (chain_nxt[b*SEGS +: SEGS]),
      .q_o   (lat[b])
    );
  end

  assign bank_a_o = lat[0];
  assign bank_b_o = half_duty_i ? lat[1] : '0;

  assign sclk_o  = now.sclk;
  assign load_o  = now.load;
  assign test_o  = now.test;
  assign blank_o = now.blank;

  assert_out_only_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sclk_o) |=> $stable(sdata_o));
  assert_banks_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_o |=> $stable(lat[0]) && $stable(lat[1]));
endmodule

// File: tb/tb_seg_serial_loader.sv
`timescale 1ns/1ps
module tb_seg_serial_loader;
  localparam int unsigned SEGS = 160;
  localparam int unsigned CH   = 2 * SEGS;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic half_duty_i = 1'b1, sdata_i = 1'b0, sclk_i = 1'b0, load_i = 1'b0;
  logic test_i = 1'b0, blank_i = 1'b0;
  logic sdata_o, sclk_o, load_o, test_o, blank_o;
  logic [SEGS-1:0] bank_a_o, bank_b_o;

  seg_serial_loader #(.SEGS(SEGS)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [CH-1:0] model = '0;
  logic [15:0] lfsr = 16'hACE1;
  logic exp_q[$];
  logic mode_q[$];
  event pulse_done;

  task automatic chk(input string req, input logic [SEGS-1:0] act, input logic [SEGS-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // one shift-clock pulse; optional load change on the rising edge
  task automatic pulse(input logic b, input logic chg_load, input logic load_val);
    @(negedge clk_i); sdata_i = b;
    repeat (3) @(negedge clk_i);
    sclk_i = 1'b1;
    if (chg_load) load_i = load_val;
    model = {model[CH-2:0], b};
    repeat (3) @(negedge clk_i);
    sclk_i = 1'b0;
    repeat (3) @(negedge clk_i);
    exp_q.push_back(half_duty_i ? model[CH-1] : model[SEGS-1]);
    mode_q.push_back(half_duty_i);
    -> pulse_done;
  endtask

  task automatic load_pulse();
    @(negedge clk_i); load_i = 1'b1;
    repeat (3) @(negedge clk_i);
    load_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic chk_banks(input string req);
    chk(req, bank_a_o, model[SEGS-1:0]);
    chk(req, bank_b_o, half_duty_i ? model[CH-1:SEGS] : '0);
  endtask

  // monitor: compares serial output after each falling edge
  initial begin
    forever begin
      @(pulse_done);
      begin
        logic e, m;
        e = exp_q.pop_front();
        m = mode_q.pop_front();
        chk(m ? "R4 sdata_o stage 2*SEGS" : "R3 sdata_o stage SEGS",
            {{(SEGS-1){1'b0}}, sdata_o}, {{(SEGS-1){1'b0}}, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1..: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [SEGS-1:0] snap_a;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state, checked in half-duty so bank B is visible
    chk("R1 reset bank_a", bank_a_o, '0);
    chk("R1 reset bank_b", bank_b_o, '0);
    chk("R1 reset sdata", {{(SEGS-1){1'b0}}, sdata_o}, '0);

    // R9 buffered copies lag by one system clock
    @(negedge clk_i); test_i = 1'b1; blank_i = 1'b1;
    #1 chk("R9 test not yet", {{(SEGS-2){1'b0}}, test_o, blank_o}, '0);
    @(negedge clk_i);
    chk("R9 test/blank copied", {{(SEGS-2){1'b0}}, test_o, blank_o}, 2'b11);
    test_i = 1'b0; blank_i = 1'b0;
    @(negedge clk_i);
    chk("R9 test/blank released", {{(SEGS-2){1'b0}}, test_o, blank_o}, '0);

    // static mode, ordering: first bit lands at segment SEGS
    half_duty_i = 1'b0;
    pulse(1'b1, 1'b0, 1'b0);
    for (int i = 1; i < SEGS; i++) pulse(1'b0, 1'b0, 1'b0);
    load_pulse();
    chk("R2 first bit at top segment", bank_a_o, {1'b1, {(SEGS-1){1'b0}}});
    chk("R8 bank_b zero in static", bank_b_o, '0);

    // static mode, pseudo-random fill
    for (int i = 0; i < SEGS; i++) pulse(next_bit(), 1'b0, 1'b0);
    load_pulse();
    chk_banks("R2 static fill");
    chk("R8 bank_b zero after fill", bank_b_o, '0);

    // R7 shifts with load low leave outputs alone
    snap_a = bank_a_o;
    for (int i = 0; i < 5; i++) pulse(next_bit(), 1'b0, 1'b0);
    chk("R7 hold while load low", bank_a_o, snap_a);

    // R6 transparency while load high
    @(negedge clk_i); load_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R6 follow on load rise", bank_a_o, model[SEGS-1:0]);
    pulse(1'b1, 1'b0, 1'b0);
    chk("R6 follow shift 1", bank_a_o, model[SEGS-1:0]);
    pulse(1'b0, 1'b0, 1'b0);
    chk("R6 follow shift 2", bank_a_o, model[SEGS-1:0]);
    @(negedge clk_i); load_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // half-duty: single one travels to bank B top
    half_duty_i = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    for (int i = 1; i < CH; i++) pulse(1'b0, 1'b0, 1'b0);
    load_pulse();
    chk("R5 first bit at bank B top", bank_b_o, {1'b1, {(SEGS-1){1'b0}}});
    chk("R5 bank A empty", bank_a_o, '0);

    // half-duty pseudo-random fill
    for (int i = 0; i < CH; i++) pulse(next_bit(), 1'b0, 1'b0);
    load_pulse();
    chk_banks("R5 half-duty fill");

    // same-cycle: load dropped with the rising edge -> pre-shift kept
    @(negedge clk_i); load_i = 1'b1;
    repeat (3) @(negedge clk_i);
    begin
      logic [CH-1:0] pre;
      pre = model;
      pulse(~model[0], 1'b1, 1'b0);
      chk("R7 load fall with shift bank_a", bank_a_o, pre[SEGS-1:0]);
      chk("R7 load fall with shift bank_b", bank_b_o, pre[CH-1:SEGS]);
    end

    // same-cycle: load raised with the rising edge -> post-shift visible
    pulse(~model[0], 1'b1, 1'b1);
    chk_banks("R6 load rise with shift");
    @(negedge clk_i); load_i = 1'b0;
    repeat (3) @(negedge clk_i);

    // R8 switch back to static: bank B masked, bank A unchanged
    half_duty_i = 1'b0;
    @(negedge clk_i);
    chk("R8 bank_b masked after switch", bank_b_o, '0);
    chk("R7 bank_a kept after switch", bank_a_o, model[SEGS-1:0]);
    for (int i = 0; i < 4; i++) pulse(next_bit(), 1'b0, 1'b0);

    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule